// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block controls reset for a microcontroller. It accepts reset requests from several sources: the shared active-low reset pin, a power-up request, requests that must line up with the bus (system reset instruction, loss of clock, test) and requests that may not wait (halt monitor, software watchdog). It then pulls the shared pin low for a fixed number of clocks. The pin is open-drain: the block only enables a low drive, and the sensed pin level comes back as an input.

Each source class follows its own start rule. A low on the pin counts only after a short qualification time, waits for the current bus cycle to finish, waits for the outside driver to let go, and then takes a two-cycle turnaround before the block drives. Bus-aligned requests wait only for the bus cycle to finish. Requests that may not wait start the drive at once. Every request seen during a sequence is gathered into one cause set. When the pin is released, that set is written into a 16-bit read-only status word.

Top module: `rst_sequencer`

## Requirements
- R1: After the synchronous reset input, `pin_drive_en`, `int_rst` and `status` are all zero.
- R2: A low on `pin_in` is accepted as a request only at the fourth consecutive clock edge that samples it low while the block is not sequencing. A low lasting three edges or fewer starts nothing and leaves `status` unchanged.
- R3: After an accepted pin request, the block waits for `bus_done`, then waits for `pin_in` to read high, then lets two cycles pass with no drive, and then starts the drive.
- R4: Each drive holds `pin_drive_en` high for exactly 512 consecutive cycles.
- R5: `sys_req`, `clk_loss_req` and `tst_req` wait for `bus_done`. It is sampled from the cycle after acceptance, and the drive begins on the edge that samples it high.
- R6: `hlt_req` and `wdg_req` start the drive on the edge that samples them, whatever `bus_done` is. This also holds when a bus-aligned request is already pending.
- R7: Status layout: bit 7 pin, bit 6 power-up, bit 5 watchdog, bit 4 halt monitor, bit 1 system reset instruction, bit 0 test. Bits 15:8 and 3:2 read zero. Loss of clock sets no bit.
- R8: `status` changes only on the edge that ends the drive. It is then loaded with exactly the causes of that sequence, replacing its old value, so several bits may be set together.
- R9: Requests that arrive during the drive are added to the cause set and do not restart or lengthen the drive.
- R10: `pwr_req` acts like an immediate request. It also discards the causes gathered so far, keeping only itself and the requests on the same edge, and it restarts the 512-cycle count.
- R11: `int_rst` is high from the edge that accepts a request until one cycle after `pin_drive_en` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| pin_in | input | 1 | Sensed level of the shared reset pin (0 = low) |
| pwr_req | input | 1 | Power-up request |
| sys_req | input | 1 | Reset-instruction request (bus-aligned) |
| clk_loss_req | input | 1 | Loss-of-clock request (bus-aligned) |
| tst_req | input | 1 | Test request (bus-aligned) |
| hlt_req | input | 1 | Halt monitor request (immediate) |
| wdg_req | input | 1 | Software watchdog request (immediate) |
| bus_done | input | 1 | Current bus cycle has completed |
| pin_drive_en | output | 1 | Enables the low drive onto the reset pin |
| int_rst | output | 1 | Internal reset to the rest of the chip |
| status | output | 16 | Read-only cause status word |

## Verification
The assertions take it that `pin_in` is low whenever `pin_drive_en` is high. In other words, the pin reads as the wired-AND of the block's own drive and an outside driver. The bench builds `pin_in` exactly that way. The assertions also take it that request inputs are pulses sampled on a single edge. The stimulus changes every request and `bus_done` only on falling clock edges, as one-cycle pulses. It releases the outside pin low before the block's drive can begin, so no level is left held across a release.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int DRIVE_CYCLES_DEF = 512;
    localparam int FILT_LEN_DEF     = 4;
    localparam int TURN_CYCLES_DEF  = 2;
    localparam int STATUS_W         = 16;

    // status bit positions (software decodes these)
    localparam int BIT_EXT = 7;
    localparam int BIT_POW = 6;
    localparam int BIT_WDG = 5;
    localparam int BIT_HLT = 4;
    localparam int BIT_SYS = 1;
    localparam int BIT_TST = 0;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_BUSWAIT = 3'd1,
        ST_EXTWAIT = 3'd2,
        ST_TURN    = 3'd3,
        ST_DRIVE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic ext;
        logic pow;
        logic wdg;
        logic hlt;
        logic sys;
        logic tst;
    } cause_t;

    function automatic logic [STATUS_W-1:0] pack_status(cause_t c);
        logic [STATUS_W-1:0] s;
        s          = '0;
        s[BIT_EXT] = c.ext;
        s[BIT_POW] = c.pow;
        s[BIT_WDG] = c.wdg;
        s[BIT_HLT] = c.hlt;
        s[BIT_SYS] = c.sys;
        s[BIT_TST] = c.tst;
        return s;
    endfunction

endpackage

// File: rtl/rstseq_ext_filter.sv
module rstseq_ext_filter #(
    parameter int FILT_LEN = rstseq_pkg::FILT_LEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic pin_in,
    output logic ext_hit
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    logic [CW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            lo_cnt <= '0;
        end else if (!pin_in) begin
            if (lo_cnt != LAST) lo_cnt <= lo_cnt + 1'b1;
        end else begin
            lo_cnt <= '0;
        end
    end

    assign ext_hit = enable && !pin_in && (lo_cnt == LAST);

    // R2: an accepted pin request was preceded by low samples
    assert_filter_len_R2: assert property (@(posedge clk) disable iff (rst)
        ext_hit |-> ($past(!pin_in, 1) && $past(!pin_in, 2) && $past(!pin_in, 3)));

endmodule

// File: rtl/rstseq_cause_merge.sv
module rstseq_cause_merge
    import rstseq_pkg::*;
(
    input  logic   ext_hit,
    input  logic   pwr_req,
    input  logic   sys_req,
    input  logic   clk_loss_req,
    input  logic   tst_req,
    input  logic   hlt_req,
    input  logic   wdg_req,
    output cause_t new_c,
    output logic   async_any,
    output logic   sync_any
);
    always_comb begin
        new_c.ext = ext_hit;
        new_c.pow = pwr_req;
        new_c.wdg = wdg_req;
        new_c.hlt = hlt_req;
        new_c.sys = sys_req;
        new_c.tst = tst_req;
    end

    assign async_any = pwr_req | hlt_req | wdg_req;
    assign sync_any  = sys_req | clk_loss_req | tst_req | ext_hit;

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYCLES = DRIVE_CYCLES_DEF,
    parameter int TURN_CYCLES  = TURN_CYCLES_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pin_in,
    input  cause_t     new_c,
    input  logic       async_any,
    input  logic       sync_any,
    input  logic       bus_done,
    output seq_state_e st,
    output logic       drive,
    output logic       load,
    output cause_t     cap_c,
    output logic       tail
);
    localparam int CNT_W = $clog2(DRIVE_CYCLES);
    localparam logic [CNT_W-1:0] DRV_LAST  = CNT_W'(DRIVE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

    seq_state_e       st_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    cause_t           acc, acc_n, merged;

    assign merged = cause_t'(acc | new_c);

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        acc_n = merged;
        load  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (async_any) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                end else if (sync_any) begin
                    st_n = ST_BUSWAIT;
                end
            end
            ST_BUSWAIT: begin
                if (async_any) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                end else if (bus_done) begin
                    st_n  = merged.ext ? ST_EXTWAIT : ST_DRIVE;
                    cnt_n = '0;
                end
            end
            ST_EXTWAIT: begin
                if (async_any) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                end else if (pin_in) begin
                    st_n  = ST_TURN;
                    cnt_n = '0;
                end
            end
            ST_TURN: begin
                if (async_any || cnt == TURN_LAST) begin
                    st_n  = ST_DRIVE;
                    cnt_n = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            ST_DRIVE: begin
                if (cnt == DRV_LAST) begin
                    st_n  = ST_IDLE;
                    cnt_n = '0;
                    acc_n = '0;
                    load  = 1'b1;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                st_n  = ST_IDLE;
                cnt_n = '0;
                acc_n = '0;
            end
        endcase
        // power-up wipes earlier causes and restarts the drive count
        if (new_c.pow) begin
            st_n  = ST_DRIVE;
            cnt_n = '0;
            acc_n = new_c;
            load  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            cnt  <= '0;
            acc  <= '0;
            tail <= 1'b0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            acc  <= acc_n;
            tail <= load;
        end
    end

    assign drive = (st == ST_DRIVE);
    assign cap_c = merged;

    // R6: an immediate request from idle starts the drive on the next cycle
    assert_async_now_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && async_any) |=> drive);

    // R5: a bus-aligned wait does not end without bus completion
    assert_sync_wait_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BUSWAIT && !bus_done && !async_any) |=> !drive);

    // R3: no drive while the pin is still held low from outside
    assert_ext_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_EXTWAIT && !pin_in && !async_any) |=> !drive);

endmodule

// File: rtl/rstseq_status_reg.sv
module rstseq_status_reg
    import rstseq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  cause_t              cap_c,
    output logic [STATUS_W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (load) begin
            status <= pack_status(cap_c);
        end
    end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int DRIVE_CYCLES = DRIVE_CYCLES_DEF,
    parameter int FILT_LEN     = FILT_LEN_DEF,
    parameter int TURN_CYCLES  = TURN_CYCLES_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                pin_in,
    input  logic                pwr_req,
    input  logic                sys_req,
    input  logic                clk_loss_req,
    input  logic                tst_req,
    input  logic                hlt_req,
    input  logic                wdg_req,
    input  logic                bus_done,
    output logic                pin_drive_en,
    output logic                int_rst,
    output logic [STATUS_W-1:0] status
);
    seq_state_e st;
    logic       filt_en, ext_hit, async_any, sync_any, load, tail;
    cause_t     new_c, cap_c;

    assign filt_en = (st == ST_IDLE) || (st == ST_BUSWAIT);

    rstseq_ext_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .enable  (filt_en),
        .pin_in  (pin_in),
        .ext_hit (ext_hit)
    );

    rstseq_cause_merge u_merge (
        .ext_hit      (ext_hit),
        .pwr_req      (pwr_req),
        .sys_req      (sys_req),
        .clk_loss_req (clk_loss_req),
        .tst_req      (tst_req),
        .hlt_req      (hlt_req),
        .wdg_req      (wdg_req),
        .new_c        (new_c),
        .async_any    (async_any),
        .sync_any     (sync_any)
    );

    rstseq_ctrl #(.DRIVE_CYCLES(DRIVE_CYCLES), .TURN_CYCLES(TURN_CYCLES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .new_c     (new_c),
        .async_any (async_any),
        .sync_any  (sync_any),
        .bus_done  (bus_done),
        .st        (st),
        .drive     (pin_drive_en),
        .load      (load),
        .cap_c     (cap_c),
        .tail      (tail)
    );

    rstseq_status_reg u_status (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cap_c  (cap_c),
        .status (status)
    );

    assign int_rst = (st != ST_IDLE) || tail;

    // R11: internal reset covers every drive cycle
    assert_int_cover_R11: assert property (@(posedge clk) disable iff (rst)
        pin_drive_en |-> int_rst);

    // R8: status moves only when the pin drive ends
    assert_status_on_release_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(status) |-> $fell(pin_drive_en));

endmodule

// File: tb/test_rst_sequencer.sv
module test_rst_sequencer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_low = 1'b0;
    logic pwr_req = 0, sys_req = 0, clk_loss_req = 0, tst_req = 0;
    logic hlt_req = 0, wdg_req = 0, bus_done = 0;
    logic pin_drive_en, int_rst;
    logic [15:0] status;
    logic pin_in;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    assign pin_in = !(ext_low || pin_drive_en);

    rst_sequencer i_rst_sequencer (
        .clk(clk), .rst(rst), .pin_in(pin_in), .pwr_req(pwr_req),
        .sys_req(sys_req), .clk_loss_req(clk_loss_req), .tst_req(tst_req),
        .hlt_req(hlt_req), .wdg_req(wdg_req), .bus_done(bus_done),
        .pin_drive_en(pin_drive_en), .int_rst(int_rst), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: phase 0 idle, 1 bus wait, 2 pin wait, 3 turn, 4 drive
    int m_phase = 0, m_cnt = 0, m_low = 0, m_acc = 0, m_status = 0;
    bit m_tail = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_cnt = 0; m_low = 0; m_acc = 0; m_status = 0; m_tail = 0;
        end else begin
            bit pin, hit, asy, syn;
            int nw;
            pin = !(ext_low || m_phase == 4);
            hit = 0;
            if (m_phase <= 1) begin
                if (!pin) begin
                    hit = (m_low >= 3);
                    if (m_low < 3) m_low++;
                end else m_low = 0;
            end else m_low = 0;
            nw = (int'(hit) << 7) | (int'(pwr_req) << 6) | (int'(wdg_req) << 5)
               | (int'(hlt_req) << 4) | (int'(sys_req) << 1) | int'(tst_req);
            asy = pwr_req || wdg_req || hlt_req;
            syn = sys_req || clk_loss_req || tst_req || hit;
            m_tail = 0;
            m_acc = m_acc | nw;
            if (pwr_req) begin
                m_acc = nw; m_phase = 4; m_cnt = 0;
            end else begin
                case (m_phase)
                    0: if (asy) begin m_phase = 4; m_cnt = 0; end
                       else if (syn) m_phase = 1;
                    1: if (asy) begin m_phase = 4; m_cnt = 0; end
                       else if (bus_done) begin m_phase = (m_acc & 'h80) ? 2 : 4; m_cnt = 0; end
                    2: if (asy) begin m_phase = 4; m_cnt = 0; end
                       else if (pin) begin m_phase = 3; m_cnt = 0; end
                    3: if (asy || m_cnt == 1) begin m_phase = 4; m_cnt = 0; end
                       else m_cnt++;
                    default: if (m_cnt == 511) begin
                            m_status = m_acc; m_acc = 0; m_phase = 0; m_cnt = 0; m_tail = 1;
                        end else m_cnt++;
                endcase
            end
        end
    end

    // per-cycle comparison and drive-run length monitor
    int run_len = 0, last_len = 0;
    bit prev_drive = 0;
    always @(negedge clk) begin
        if (!rst) begin
            chk("R4/R3/R5/R6 drive", int'(pin_drive_en), int'(m_phase == 4));
            chk("R11 int_rst", int'(int_rst), int'(m_phase != 0 || m_tail));
            chk("R8/R7 status", int'(status), m_status);
        end
        if (pin_drive_en) run_len++;
        else if (prev_drive) begin last_len = run_len; run_len = 0; end
        prev_drive = pin_drive_en;
    end

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        int guard = 0;
        while (int_rst && guard < 5000) begin tick(); guard++; end
        tick(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog expired, sequence hung");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk("R1 drive after reset", int'(pin_drive_en), 0);
        chk("R1 int_rst after reset", int'(int_rst), 0);
        chk("R1 status after reset", int'(status), 0);
        rst = 1'b0;
        tick(2);

        // R2: a short pin low is ignored
        ext_low = 1; tick(3); ext_low = 0; tick(6);
        chk("R2 short low no drive", int'(int_rst), 0);
        chk("R2 short low status", int'(status), 0);

        // R5: bus-aligned request waits for bus completion
        sys_req = 1; tick(); sys_req = 0;
        chk("R5 waiting int_rst", int'(int_rst), 1);
        tick(4);
        chk("R5 no drive before bus_done", int'(pin_drive_en), 0);
        bus_done = 1; tick(); bus_done = 0;
        chk("R5 drive after bus_done", int'(pin_drive_en), 1);
        wait_done();
        chk("R4 drive length sys", last_len, 512);
        chk("R7 status sys bit", int'(status), 'h0002);

        // R6 + R4 + R11: watchdog starts at once, exact timing of release
        wdg_req = 1; tick(); wdg_req = 0;
        chk("R6 immediate drive", int'(pin_drive_en), 1);
        tick(511);
        chk("R4 last drive cycle", int'(pin_drive_en), 1);
        tick();
        chk("R4 drive off after 512", int'(pin_drive_en), 0);
        chk("R11 int_rst tail cycle", int'(int_rst), 1);
        chk("R8 status at release", int'(status), 'h0020);
        tick();
        chk("R11 int_rst released", int'(int_rst), 0);
        tick(3);

        // R3: pin request with turnaround; replaces previous status (R8)
        bus_done = 1;
        ext_low = 1; tick(10);
        chk("R3 no drive while held", int'(pin_drive_en), 0);
        ext_low = 0; tick();
        chk("R3 turn cycle 1", int'(pin_drive_en), 0);
        tick();
        chk("R3 turn cycle 2", int'(pin_drive_en), 0);
        tick();
        chk("R3 drive after turn", int'(pin_drive_en), 1);
        bus_done = 0;
        wait_done();
        chk("R8 status replaced by pin", int'(status), 'h0080);

        // R9: merged requests, no restart
        sys_req = 1; tst_req = 1; tick(); sys_req = 0; tst_req = 0;
        bus_done = 1; tick(); bus_done = 0;
        tick(50);
        hlt_req = 1; tick(); hlt_req = 0;
        wait_done();
        chk("R9 length unchanged", last_len, 512);
        chk("R9 merged causes", int'(status), 'h0013);

        // R7: loss of clock sets no bit
        clk_loss_req = 1; tick(); clk_loss_req = 0;
        bus_done = 1; tick(); bus_done = 0;
        wait_done();
        chk("R7 loss of clock no bit", int'(status), 'h0000);

        // R6: halt request cuts a pending bus wait
        sys_req = 1; tick(); sys_req = 0;
        tick(3);
        hlt_req = 1; tick(); hlt_req = 0;
        chk("R6 drive despite bus wait", int'(pin_drive_en), 1);
        wait_done();
        chk("R6 status halt+sys", int'(status), 'h0012);

        // R10: power-up wipes causes and restarts count
        wdg_req = 1; tick(); wdg_req = 0;
        tick(99);
        pwr_req = 1; tick(); pwr_req = 0;
        wait_done();
        chk("R10 restarted length", last_len, 612);
        chk("R10 only power-up recorded", int'(status), 'h0040);

        // R2: exactly four low edges is enough
        ext_low = 1; tick(4); ext_low = 0;
        chk("R2 four lows accepted", int'(int_rst), 1);
        bus_done = 1; tick(); bus_done = 0;
        wait_done();
        chk("R2 pin cause recorded", int'(status), 'h0080);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule